// File: doc/BRIEF.md
# Boundary-Scan Self-Test Engine

This block holds the eighteen boundary cells of an octal scan register and runs their built-in self-test operations. Each cell has a shift stage and a shadow latch. There are eight input cells, eight output cells and two control cells. The shift stages advance on the rising edge of the test clock. The shadow latches copy them on the following falling edge and drive the values that leave the block:

- the input-cell shadows go toward the core logic;
- the output-cell shadows go toward the device pins;
- the control-cell shadows select pin drive and auxiliary control.

A two-bit opcode selects the operation. The operation advances only while both of these hold:

- the run-test instruction is the current instruction;
- the TAP controller reports Run-Test/Idle.

The TAP controller, the instruction decoder and the serial scan path are outside this block. The scan path delivers a seed or a pattern through a parallel load strobe, which writes all eighteen shift stages at once.

Top module: `bscan_bist_engine`

## Requirements
- R1: With opcode 2'b00 active, on each rising edge the input cells capture `pins_i` and every output cell inverts its value. The next falling edge presents these values on `core_o` and `pin_o`.
- R2: With opcode 2'b01 active, the 16 stages {output cells bits 15:8, input cells bits 7:0} shift one place toward bit 15 on each rising edge. The new bit 0 is s[15]^s[13]^s[12]^s[10], which gives the polynomial x^16+x^14+x^13+x^11+1.
- R3: With opcode 2'b10 active, the 16 stages perform the R2 shift, and `pins_i` is then XORed into bits 7:0 in the same edge.
- R4: With opcode 2'b11 active, two 8-bit registers run side by side. The input cells shift toward bit 7 with new bit 0 = b7^b5^b4^b3, and `pins_i` is XORed into them. The output cells run the same 8-bit shift, feedback o7^o5^o4^o3 (x^8+x^6+x^5+x^4+1), with no input.
- R5: In opcode 2'b01, an all-zero seed in the 16 stages stays all-zero.
- R6: Unless both `run_test_i` and `rti_i` are high, the shift stages and the shadow outputs hold their values.
- R7: The control cells (bit 16 shown on `oe_o`, bit 17 shown on `aux_ctrl_o`) are never changed by any test operation. `oe_o` is high when the output pins are to be driven.
- R8: The outputs change only on the falling edge. Just after a rising edge they still show the previous values.
- R9: `load_i` high at a rising edge writes `load_data_i` into the stages, with bits 7:0 to the input cells, 15:8 to the output cells, 16 to the drive-enable cell and 17 to the auxiliary cell. Load takes priority over a test operation, and the shadows follow on the next falling edge.
- R10: While `rst_ni` is low, all shift stages and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_test_i | input | 1 | Run-test instruction is current |
| rti_i | input | 1 | TAP is in Run-Test/Idle |
| opcode_i | input | 2 | Test operation select |
| pins_i | input | 8 | Device input pins |
| load_i | input | 1 | Parallel load of scanned contents |
| load_data_i | input | 18 | Scanned register contents |
| core_o | output | 8 | Input-cell shadows to core logic |
| pin_o | output | 8 | Output-cell shadows to pins |
| oe_o | output | 1 | Drive-enable cell shadow |
| aux_ctrl_o | output | 1 | Auxiliary control cell shadow |

## Verification
The bench runs long pattern-generation and signature runs from known seeds and compares them with its own model. Reversed taps or the wrong shift direction drift away from the model within a few cycles. Because the signature input stimulus differs on every cycle, an XOR into the wrong byte or an XOR placed before the shift shows up as a mismatch. The bench also checks:

- an all-zero seed, to catch any inverted feedback;
- a gated run with only one of the two enables high, to catch a mode that keeps running;
- the outputs sampled just after the rising edge, to expose shadows that update on the wrong edge;
- the control cells after every test mode, to find algorithms that leak into bits 17:16.

// File: rtl/bscan_bist_pkg.sv
package bscan_bist_pkg;
  localparam int CELLS_W = 8;
  localparam int WORD_W  = 2 * CELLS_W;
  localparam int REG_W   = WORD_W + 2;

  typedef enum logic [1:0] {
    OP_SAMPLE_TOGGLE = 2'b00,
    OP_PATGEN16      = 2'b01,
    OP_SIG16         = 2'b10,
    OP_SIG_PAT8      = 2'b11
  } bist_op_e;

  function automatic logic [WORD_W-1:0] lfsr16_step(input logic [WORD_W-1:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [CELLS_W-1:0] lfsr8_step(input logic [CELLS_W-1:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
endpackage

// File: rtl/bscan_shift_stages.sv
module bscan_shift_stages
  import bscan_bist_pkg::*;
(
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  bist_op_e          op_i,
  input  logic [CELLS_W-1:0] pins_i,
  input  logic              load_i,
  input  logic [REG_W-1:0]  load_data_i,
  output logic [REG_W-1:0]  sr_o,
  output logic              upd_o
);
  logic [CELLS_W-1:0] in_q, out_q, in_d, out_d;
  logic [1:0]         ctl_q;
  logic [WORD_W-1:0]  w16;

  always_comb begin
    w16   = lfsr16_step({out_q, in_q});
    in_d  = in_q;
    out_d = out_q;
    unique case (op_i)
      OP_SAMPLE_TOGGLE: begin in_d = pins_i; out_d = ~out_q; end
      OP_PATGEN16:      {out_d, in_d} = w16;
      OP_SIG16:         {out_d, in_d} = w16 ^ {{CELLS_W{1'b0}}, pins_i};
      OP_SIG_PAT8: begin
        in_d  = lfsr8_step(in_q) ^ pins_i;
        out_d = lfsr8_step(out_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= '0;
      ctl_q <= '0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= load_i | act_i;
      if (load_i) begin
        {ctl_q, out_q, in_q} <= load_data_i;
      end else if (act_i) begin
        in_q  <= in_d;
        out_q <= out_d;
      end
    end
  end

  assign sr_o = {ctl_q, out_q, in_q};

  a_r6_hold: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!act_i && !load_i) |=> $stable(sr_o));
  a_r7_ctrl_fixed: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !load_i |=> $stable(sr_o[REG_W-1:WORD_W]));
  a_r5_zero_seed: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (act_i && !load_i && op_i == OP_PATGEN16 && sr_o[WORD_W-1:0] == '0)
      |=> sr_o[WORD_W-1:0] == '0);
  a_r1_toggle: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (act_i && !load_i && op_i == OP_SAMPLE_TOGGLE)
      |=> sr_o[WORD_W-1:CELLS_W] == ~$past(sr_o[WORD_W-1:CELLS_W]));
endmodule

// File: rtl/bscan_shadow_latches.sv
module bscan_shadow_latches
  import bscan_bist_pkg::*;
(
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [REG_W-1:0] sr_i,
  output logic [REG_W-1:0] shd_o
);
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)    shd_o <= '0;
    else if (upd_i) shd_o <= sr_i;
  end

  a_r8_shadow_hold: assert property (@(negedge tck_i) disable iff (!rst_ni)
    !upd_i |=> $stable(shd_o));
  a_r8_shadow_copy: assert property (@(negedge tck_i) disable iff (!rst_ni)
    upd_i |=> shd_o == $past(sr_i));
endmodule

// File: rtl/bscan_bist_engine.sv
module bscan_bist_engine
  import bscan_bist_pkg::*;
(
  input  logic        tck_i,
  input  logic        rst_ni,
  input  logic        run_test_i,
  input  logic        rti_i,
  input  logic [1:0]  opcode_i,
  input  logic [7:0]  pins_i,
  input  logic        load_i,
  input  logic [17:0] load_data_i,
  output logic [7:0]  core_o,
  output logic [7:0]  pin_o,
  output logic        oe_o,
  output logic        aux_ctrl_o
);
  logic [REG_W-1:0] sr, shd;
  logic             upd, act;

  assign act = run_test_i & rti_i;

  bscan_shift_stages u_shift (
    .tck_i, .rst_ni, .act_i(act), .op_i(bist_op_e'(opcode_i)), .pins_i,
    .load_i, .load_data_i, .sr_o(sr), .upd_o(upd)
  );

  bscan_shadow_latches u_shadow (
    .tck_i, .rst_ni, .upd_i(upd), .sr_i(sr), .shd_o(shd)
  );

  assign core_o     = shd[CELLS_W-1:0];
  assign pin_o      = shd[WORD_W-1:CELLS_W];
  assign oe_o       = shd[WORD_W];
  assign aux_ctrl_o = shd[WORD_W+1];

  a_r10_reset_outputs: assert property (@(posedge tck_i)
    !rst_ni |-> (core_o == '0 && pin_o == '0 && !oe_o && !aux_ctrl_o));
endmodule

// File: tb/tb_bscan_bist_engine.sv
`timescale 1ns/100ps
module tb_bscan_bist_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        run_test = 1'b0, rti = 1'b0, load = 1'b0;
  logic [1:0]  opcode = 2'b00;
  logic [7:0]  pins = '0;
  logic [17:0] load_data = '0;
  logic [7:0]  core, pin;
  logic        oe, aux;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  bscan_bist_engine dut (
    .tck_i(clk), .rst_ni(rst_n), .run_test_i(run_test), .rti_i(rti),
    .opcode_i(opcode), .pins_i(pins), .load_i(load), .load_data_i(load_data),
    .core_o(core), .pin_o(pin), .oe_o(oe), .aux_ctrl_o(aux)
  );

  // {pins, expected core, expected pin} for sample/toggle after loading out=A5
  localparam logic [23:0] VEC [4] = '{
    {8'h3C, 8'h3C, 8'h5A}, {8'hC3, 8'hC3, 8'hA5},
    {8'hFF, 8'hFF, 8'h5A}, {8'h00, 8'h00, 8'hA5}
  };

  logic [17:0] m;  // bench model of the stages

  function automatic logic [17:0] model(logic [17:0] s, logic [1:0] op, logic [7:0] p);
    logic [15:0] w;
    logic [7:0]  a, b;
    w = s[15:0]; a = s[7:0]; b = s[15:8];
    case (op)
      2'b00: begin a = p; b = ~b; w = {b, a}; end
      2'b01: w = {w[14:0], w[15] ^ w[13] ^ w[12] ^ w[10]};
      2'b10: w = {w[14:0], w[15] ^ w[13] ^ w[12] ^ w[10]} ^ {8'h00, p};
      default: begin
        a = {a[6:0], a[7] ^ a[5] ^ a[4] ^ a[3]} ^ p;
        b = {b[6:0], b[7] ^ b[5] ^ b[4] ^ b[3]};
        w = {b, a};
      end
    endcase
    return {s[17:16], w};
  endfunction

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] outs();
    return {aux, oe, pin, core};
  endfunction

  // one full clock; inputs set beforehand, outputs sampled after the falling edge
  task automatic tick();
    @(posedge clk); #0.5;
    @(negedge clk); #0.5;
  endtask

  task automatic do_load(logic [17:0] d);
    load = 1'b1; load_data = d; tick(); load = 1'b0; m = d;
  endtask

  task automatic run_mode(string req, logic [1:0] op, logic [17:0] seed, int n, int pin_salt);
    do_load(seed);
    run_test = 1'b1; rti = 1'b1; opcode = op;
    for (int i = 0; i < n; i++) begin
      pins = 8'(i * pin_salt + 8'h1B);
      m = model(m, op, pins);
      tick();
      chk(req, outs(), m);
    end
    run_test = 1'b0; rti = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #5;
    chk("R10 reset", outs(), '0);
    @(negedge clk); rst_n = 1'b1; #0.5;

    // R1 table walk
    do_load({2'b01, 8'hA5, 8'h00});
    chk("R9 load", outs(), {2'b01, 8'hA5, 8'h00});
    run_test = 1'b1; rti = 1'b1; opcode = 2'b00;
    for (int i = 0; i < 4; i++) begin
      pins = VEC[i][23:16];
      tick();
      chk("R1 sample/toggle", {2'b00, pin, core}, {2'b00, VEC[i][7:0], VEC[i][15:8]});
      chk("R7 ctrl untouched", {16'h0, aux, oe}, {16'h0, 2'b01});
    end

    // R8: just after rising edge outputs still old
    pins = 8'h77;
    @(posedge clk); #0.5;
    chk("R8 no change on rise", {2'b01, pin, core}, {2'b01, VEC[3][7:0], VEC[3][15:8]});
    @(negedge clk); #0.5;
    chk("R8 change on fall", {2'b01, pin, core}, {2'b01, 8'h5A, 8'h77});
    run_test = 1'b0; rti = 1'b0;

    run_mode("R2 patgen16", 2'b01, {2'b10, 16'hACE1}, 40, 0);
    run_mode("R3 sig16", 2'b10, {2'b11, 16'h1234}, 30, 37);
    run_mode("R4 sig/pat8", 2'b11, {2'b00, 16'h5C01}, 30, 53);
    chk("R7 ctrl after modes", {16'h0, aux, oe}, 18'h0);

    // R5 all-zero seed
    run_mode("R5 zero seed", 2'b01, {2'b01, 16'h0000}, 5, 0);
    chk("R5 still zero", outs(), {2'b01, 16'h0000});

    // R6 hold with only one enable
    do_load({2'b00, 16'hBEEF});
    opcode = 2'b01; run_test = 1'b1; rti = 1'b0; tick();
    chk("R6 rti low hold", outs(), {2'b00, 16'hBEEF});
    run_test = 1'b0; rti = 1'b1; tick();
    chk("R6 run_test low hold", outs(), {2'b00, 16'hBEEF});
    rti = 1'b0;

    // R9 load beats active mode
    run_test = 1'b1; rti = 1'b1; opcode = 2'b00;
    do_load({2'b10, 16'h0F0F});
    chk("R9 load priority", outs(), {2'b10, 16'h0F0F});
    run_test = 1'b0; rti = 1'b0;

    // R10 async reset mid-run
    #1 rst_n = 1'b0; #0.5;
    chk("R10 async reset", outs(), '0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule